// File: doc/BRIEF.md
# SPD Read Target

This block is the read side of a two-wire serial target sitting in front of a 256-byte store, the kind used to hold module identification data on a memory stick. It watches the clock and data lines, oversampled by the system clock, and finds Start, repeated Start and Stop conditions. It then decodes a select byte and answers reads. It pulls the data line low through an open-drain style output, both for its own acknowledge bits and for the zero bits of the data it returns.

A single 8-bit pointer supplies the address for every read. A write transfer carries one word-address byte into that pointer. That byte is acknowledged, and the pointer is usable right away, with no Stop needed. The controller can follow it with a repeated Start and a read select to fetch from a chosen address. It can also open a read directly and continue from wherever the pointer stands. Each time the controller acknowledges a returned byte, the next byte follows. The store is filled through a side loading port. No write cycle to the array, no protection logic and no clock stretching exist here.

Top module: `spd_read_target`

## Requirements
- R1: A fall of SDA while SCL is high is a Start. It abandons any transfer in progress, even one halfway through an address byte, and begins select decoding. A rise of SDA while SCL is high is a Stop and leaves the target idle, so bits clocked after a Stop and before the next Start get no acknowledge. After reset SDA is released.
- R2: The select byte arrives MSB first. Bits [7:4] must be 4'b1010, bits [3:1] must equal `strap_i[2:0]`, and bit 0 is R/W (1 = read). When it does not match, the target never pulls SDA low before the next Start.
- R3: A matching select byte, and the word-address byte of a write, are acknowledged by pulling SDA low for the whole 9th clock.
- R4: The word-address byte of a write (R/W = 0) loads the pointer. A repeated Start with a read select then returns the byte stored at that address.
- R5: A read select sent straight after a Start, with no address phase, returns the byte at the current pointer value.
- R6: The pointer advances by one after every byte returned, including a byte the controller does not acknowledge. It does not move at any other time.
- R7: If the controller acknowledges a returned byte (SDA low on the 9th clock), the byte at the next address is shifted out on the following eight clocks.
- R8: The pointer wraps from FFh to 00h, and a sequential read carries on across that boundary without a break.
- R9: If SDA is high on the 9th clock after a returned byte, the target releases SDA and ignores further clocks until a Start or Stop.
- R10: Data bits leave MSB first, and SDA, as driven by the target, changes only while SCL is low.
- R11: A write on the loading port (`ld_en_i`, `ld_addr_i`, `ld_data_i`) stores the byte, and later reads of that address return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| strap_i | input | 3 | Chip-enable straps compared with select bits [3:1] |
| ld_en_i | input | 1 | Loading port write strobe |
| ld_addr_i | input | 8 | Loading port address |
| ld_data_i | input | 8 | Loading port data |

## Verification
The bench builds the block with its defaults: an 8-bit pointer, 8-bit data, three strap bits and a two-flop synchroniser. An 8-bit pointer means the FFh-to-00h wrap is reached in a few bytes, both inside one sequential read and across separate single-byte reads. With the SCL half period set to eight system clocks, the synchroniser delay plus the registered pull land well inside the low phase, and the bench can sample the line twice in each high phase to confirm the data is stable.

// File: rtl/spd_rd_pkg.sv
package spd_rd_pkg;

  // Serial-side protocol states of the read engine
  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACKP,
    S_DEV_ACK,
    S_ADDR,
    S_ADDR_ACKP,
    S_ADDR_ACK,
    S_TX,
    S_MACK,
    S_MACK_OK,
    S_WAIT
  } rd_state_e;

  // Fixed device type nibble carried in the top of the select byte
  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] lvl_q;

  assign raw = {scl_i, sda_i};

  // One synchroniser chain per line; idle bus level is high
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= '1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
      end
    end
    assign lvl[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '1;
    end else begin
      lvl_q <= lvl;
    end
  end

  assign scl_lvl_o  = lvl[1];
  assign sda_lvl_o  = lvl[0];
  assign scl_rise_o = lvl[1] & ~lvl_q[1];
  assign scl_fall_o = ~lvl[1] & lvl_q[1];
  assign start_o    = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
  assign stop_o     = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];

endmodule

// File: rtl/spd_byte_store.sv
module spd_byte_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // Registered read follows the pointer every cycle
  always_ff @(posedge clk) begin
    rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/spd_rd_ctrl.sv
module spd_rd_ctrl
  import spd_rd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [CE_W-1:0]   strap_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              sda_pull_o
);

  localparam int              CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  rd_state_e         st_q,   st_n;
  logic [CNT_W-1:0]  cnt_q,  cnt_n;
  logic [DATA_W-1:0] sh_q,   sh_n;
  logic [ADDR_W-1:0] ptr_q,  ptr_n;
  logic              rw_q,   rw_n;
  logic              pull_q, pull_n;
  logic [DATA_W-1:0] rx_byte;
  logic              sel_hit;
  logic              ev_en;

  assign rx_byte = {sh_q[DATA_W-2:0], sda_i};
  assign sel_hit = (rx_byte[DATA_W-1 -: 4] == DEV_TYPE_CODE) &&
                   (rx_byte[CE_W:1] == strap_i);
  assign ev_en   = scl_rise_i | scl_fall_i | start_i | stop_i;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    ptr_n = ptr_q;
    rw_n  = rw_q;
    if (start_i) begin
      st_n  = S_DEV;
      cnt_n = '0;
    end else if (stop_i) begin
      st_n  = S_IDLE;
    end else begin
      case (st_q)
        S_DEV: begin
          if (scl_rise_i) begin
            sh_n  = rx_byte;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_n = '0;
              if (sel_hit) begin
                st_n = S_DEV_ACKP;
                rw_n = sda_i;
              end else begin
                st_n = S_WAIT;
              end
            end
          end
        end
        S_DEV_ACKP: if (scl_fall_i) st_n = S_DEV_ACK;
        S_DEV_ACK: begin
          if (scl_fall_i) begin
            cnt_n = '0;
            if (rw_q) begin
              st_n = S_TX;
              sh_n = rd_data_i;
            end else begin
              st_n = S_ADDR;
            end
          end
        end
        S_ADDR: begin
          if (scl_rise_i) begin
            sh_n  = rx_byte;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_n = '0;
              ptr_n = rx_byte[ADDR_W-1:0];
              st_n  = S_ADDR_ACKP;
            end
          end
        end
        S_ADDR_ACKP: if (scl_fall_i) st_n = S_ADDR_ACK;
        S_ADDR_ACK:  if (scl_fall_i) st_n = S_WAIT;
        S_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == LAST_BIT) begin
              st_n  = S_MACK;
              cnt_n = '0;
              ptr_n = ptr_q + 1'b1;
            end else begin
              sh_n  = {sh_q[DATA_W-2:0], 1'b0};
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        S_MACK: if (scl_rise_i) st_n = sda_i ? S_WAIT : S_MACK_OK;
        S_MACK_OK: begin
          if (scl_fall_i) begin
            st_n  = S_TX;
            sh_n  = rd_data_i;
            cnt_n = '0;
          end
        end
        default: ;
      endcase
    end
    pull_n = (st_n == S_DEV_ACK) || (st_n == S_ADDR_ACK) ||
             ((st_n == S_TX) && !sh_n[DATA_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      pull_q <= 1'b0;
    end else if (ev_en) begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      ptr_q  <= ptr_n;
      rw_q   <= rw_n;
      pull_q <= pull_n;
    end
  end

  assign ptr_o      = ptr_q;
  assign sda_pull_o = pull_q;

  // R2 / R9: a target that has given up on the transfer keeps SDA released
  p_wait_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) |-> !pull_q);

  // R9: no acknowledge on the 9th clock sends the engine to standby
  p_nack_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_MACK && scl_rise_i && sda_i && !start_i && !stop_i)
    |=> (st_q == S_WAIT && !pull_q));

  // R8: the last address is followed by address zero
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TX && scl_fall_i && cnt_q == LAST_BIT &&
     ptr_q == {ADDR_W{1'b1}} && !start_i && !stop_i)
    |=> (ptr_q == '0));

  // R6: the pointer holds during select and acknowledge phases
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {S_DEV_ACKP, S_DEV_ACK, S_MACK, S_MACK_OK, S_WAIT, S_IDLE})
    |=> $stable(ptr_q));

endmodule

// File: rtl/spd_read_target.sv
module spd_read_target #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CE_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [CE_W-1:0]   strap_i,
  input  logic              ld_en_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  core_rst_n;
  logic                  scl_lvl, sda_lvl;
  logic                  scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0]     ptr;
  logic [DATA_W-1:0]     rd_data;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe_q[RST_STAGES-1];

  spd_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_lvl_o  (scl_lvl),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  spd_byte_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk     (clk),
    .we_i    (ld_en_i),
    .waddr_i (ld_addr_i),
    .wdata_i (ld_data_i),
    .raddr_i (ptr),
    .rdata_o (rd_data)
  );

  spd_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CE_W(CE_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_i      (sda_lvl),
    .strap_i    (strap_i),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .sda_pull_o (sda_pull_o)
  );

  // R10: the target moves SDA only while the sampled clock is low
  p_sda_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    !$stable(sda_pull_o) |-> !scl_lvl);

endmodule

// File: tb/test_spd_read_target.sv
module test_spd_read_target;

  localparam int HALF  = 8;
  localparam int QTR   = 4;
  localparam int NVEC  = 8;
  localparam int WDOG  = 100000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};

  // {mode(1=random,0=current), address, byte count}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h1_10_1, 16'h0_00_1, 16'h1_40_4, 16'h1_FE_4,
    16'h0_00_2, 16'h1_FF_1, 16'h0_00_1, 16'h1_80_3
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_pull;
  logic       sda_bus;
  logic       ld_en;
  logic [7:0] ld_addr, ld_data;
  logic [7:0] mem_m [256];
  int         ptr_m;
  int         n_checks = 0;
  int         n_fail   = 0;

  assign sda_bus = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  spd_read_target i_spd_read_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_pull_o (sda_pull),
    .strap_i    (STRAP),
    .ld_en_i    (ld_en),
    .ld_addr_i  (ld_addr),
    .ld_data_i  (ld_data)
  );

  function automatic logic [7:0] pat(input int a);
    logic [7:0] t;
    t = 8'(a * 37 + 11);
    return t ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clk_bit(input logic v, output logic s1, output logic s2);
    sda_m = v;
    tick();
    scl_m = 1'b1;
    repeat (QTR) @(negedge clk);
    s1 = sda_bus;
    repeat (QTR) @(negedge clk);
    s2 = sda_bus;
    scl_m = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b0; tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b1; tick();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic acked);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], a1, a2);
    clk_bit(1'b1, a1, a2);
    acked = !a1 && !a2;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d, output logic stable);
    logic s1, s2;
    d = '0;
    stable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s1, s2);
      d = {d[6:0], s1};
      if (s1 != s2) stable = 1'b0;
    end
    clk_bit(!mack, s1, s2);
  endtask

  task automatic preload(input int a, input logic [7:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 8'(a); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    mem_m[a] = v;
  endtask

  task automatic read_run(input int n, input bit random_mode);
    logic [7:0] d;
    logic       stb;
    string      tag;
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, d, stb);
      if (k == 0) tag = random_mode ? "R4" : "R5 R6";
      else        tag = (ptr_m == 0) ? "R8" : "R7";
      chk(d == mem_m[ptr_m], tag, d, mem_m[ptr_m]);
      chk(stb, "R10", stb, 1);
      ptr_m = (ptr_m + 1) % 256;
    end
  endtask

  task automatic open_random(input logic [7:0] a);
    logic ack;
    bus_start();
    write_byte(SEL_W, ack);
    chk(ack, "R3", ack, 1);
    write_byte(a, ack);
    chk(ack, "R3", ack, 1);
    bus_start();
    write_byte(SEL_R, ack);
    chk(ack, "R3", ack, 1);
    ptr_m = a;
  endtask

  task automatic open_current();
    logic ack;
    bus_start();
    write_byte(SEL_R, ack);
    chk(ack, "R3", ack, 1);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d cycles at most", WDOG, WDOG);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic       ack;
    logic [7:0] d;
    logic       stb;
    logic       s1, s2;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    ptr_m = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: released after reset
    chk(sda_pull == 1'b0 && sda_bus == 1'b1, "R1", sda_pull, 0);

    // R11: fill the store through the loading port
    for (int a = 0; a < 256; a++) preload(a, pat(a));

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][12]) open_random(VEC[v][11:4]);
      else            open_current();
      read_run(int'(VEC[v][3:0]), VEC[v][12]);
      bus_stop();
    end

    // R2: wrong straps, no acknowledge and nothing driven
    bus_start();
    write_byte({4'b1010, 3'b010, 1'b1}, ack);
    chk(!ack, "R2", ack, 0);
    read_byte(1'b0, d, stb);
    chk(d == 8'hFF, "R2", d, 8'hFF);
    bus_stop();

    // R2: wrong type nibble
    bus_start();
    write_byte({4'b1011, STRAP, 1'b1}, ack);
    chk(!ack, "R2", ack, 0);
    bus_stop();

    // R1: select bits after a Stop without a Start are ignored
    write_byte(SEL_R, ack);
    chk(!ack, "R1", ack, 0);
    bus_stop();

    // R9: no acknowledge, then extra clocks see a released line
    open_random(8'h20);
    read_byte(1'b0, d, stb);
    chk(d == mem_m[8'h20], "R4", d, mem_m[8'h20]);
    read_byte(1'b0, d, stb);
    chk(d == 8'hFF, "R9", d, 8'hFF);
    bus_stop();

    // R6: counter moved once for the unacknowledged byte only
    open_current();
    read_byte(1'b0, d, stb);
    chk(d == mem_m[8'h21], "R6", d, mem_m[8'h21]);
    bus_stop();

    // R1: Start in the middle of the address byte aborts the load
    bus_start();
    write_byte(SEL_W, ack);
    chk(ack, "R3", ack, 1);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s1, s2);
    bus_start();
    write_byte(SEL_R, ack);
    chk(ack, "R1", ack, 1);
    read_byte(1'b0, d, stb);
    chk(d == mem_m[8'h22], "R1", d, mem_m[8'h22]);
    bus_stop();

    // R11: overwrite one location and read it back
    preload(8'h05, 8'hC3);
    open_random(8'h05);
    read_byte(1'b0, d, stb);
    chk(d == 8'hC3, "R11", d, 8'hC3);
    bus_stop();

    repeat (10) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule